// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Ring

This block records a probe vector into an on-chip ring memory, one sample every clock, from the moment it is armed. It keeps a programmable number of samples from before a trigger event. It keeps the sample taken when the trigger is accepted, and a programmable number of samples after it. Capture then stops. The memory is an inferred two-port array. One port takes samples and the other serves readout once capture has finished.

The arm, trigger and probe inputs pass together through a parameterized chain of register stages, so a trigger always refers to the probe value sampled on the same clock edge. A trigger that arrives before enough history exists is ignored. Once capture ends, `done` stays high and the window is streamed out oldest first on a valid/ready port. The trigger sample sits at beat position `pre` (counting from zero).

The stream follows the usual rules. A beat transfers on a rising edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` hold their values. `rd_ready` may be held low for any length of time. The probe input has no back-pressure: it is sampled every clock while capturing. A new arm pulse in any state abandons the current capture or readout.

Top module: `trace_window_recorder`

## Requirements
- R1: While and after reset, `busy`, `done`, `rd_valid` and `rd_last` are low.
- R2: `arm`, `trig` and `probe` are delayed together by PIPE register stages (default 2). `busy` is high after the (PIPE+1)-th rising edge counted from the edge that samples `arm`.
- R3: The sample taken on the arming edge is sample 0 and goes to address 0. Sample k goes to address k mod DEPTH, one per clock, overwriting older data. After capture, `trig_addr` equals the index of the accepted trigger sample mod DEPTH.
- R4: A trigger on sample k is ignored when k < pre, where pre is the pre-trigger count. The capture keeps waiting for a later trigger.
- R5: Capture ends with sample trig+post, so a post count of zero ends it on the trigger sample itself. That last sample is sampled at edge e. `done` is high and `busy` is low after edge e+PIPE. No later sample is written.
- R6: Readout delivers exactly pre+post+1 beats, starting at address (trig_addr − pre) mod DEPTH and moving in time order. `rd_last` is high on the final beat only. `rd_valid` then stays low.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_last` are held and no beat is lost.
- R8: `done` stays high until the next arm pulse. An arm pulse in any state restarts with no history and cancels readout, so the R4 qualification counts only samples since the new arm.
- R9: `pre_cnt` and `post_cnt` are captured on the edge that samples `arm`. Later changes do not affect that capture. The user must keep pre+post+1 ≤ DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| probe | input | DW | Probe vector sampled every clock while capturing |
| arm | input | 1 | One-cycle pulse that starts a fresh capture |
| trig | input | 1 | Trigger pulse, aligned with the probe value of the same cycle |
| pre_cnt | input | AW | Samples kept before the trigger |
| post_cnt | input | AW | Samples kept after the trigger |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished and window held |
| trig_addr | output | AW | Memory address of the trigger sample |
| rd_valid | output | 1 | Readout beat available |
| rd_ready | input | 1 | Consumer accepts a readout beat |
| rd_data | output | DW | Readout sample |
| rd_last | output | 1 | Marks the final beat of the window |

## Verification
The hardest case to reach is a re-arm during a capture that already has more history than the new pre count demands. A wrong design would carry the old fill over and accept an early trigger. The stimulus aborts a running capture after ten samples. It re-arms with a pre count of six and fires a trigger at new sample three, which must be ignored. A second trigger at sample nine must be accepted. Windows that cross the memory wrap and that fill the entire memory are read out under an irregular ready pattern, which checks the rotation and the stall holding together.

// File: rtl/trace_pkg.sv
package trace_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;

endpackage

// File: rtl/trace_pipe.sv
module trace_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end

      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; output holds when not enabled
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_arm,
  input  logic          s_trig,
  input  logic [AW-1:0] cfg_pre,
  input  logic [AW-1:0] cfg_post,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] trig_addr,
  output logic          busy,
  output logic          done
);

  localparam int          DEPTH    = 1 << AW;
  localparam logic [AW:0] FILL_MAX = (AW+1)'(DEPTH);

  cap_state_e    st;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] post_left;
  logic [AW:0]   fill;
  logic [AW:0]   cur_fill;
  logic [AW-1:0] cur_addr;
  logic          seeking;
  logic          capturing;
  logic          trig_ok;

  // an arm pulse restarts from an empty buffer in the same cycle
  always_comb begin
    cur_fill  = s_arm ? '0 : fill;
    cur_addr  = s_arm ? '0 : wr_ptr;
    seeking   = s_arm || (st == ST_FILL);
    capturing = seeking || (st == ST_POST);
    trig_ok   = seeking && s_trig && (cur_fill >= {1'b0, cfg_pre});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      wr_ptr    <= '0;
      post_left <= '0;
      fill      <= '0;
      trig_addr <= '0;
    end else if (capturing) begin
      wr_ptr <= cur_addr + 1'b1;
      if (cur_fill != FILL_MAX) fill <= cur_fill + 1'b1;
      else                      fill <= cur_fill;
      if (seeking) begin
        st <= ST_FILL;
        if (trig_ok) begin
          trig_addr <= cur_addr;
          if (cfg_post == '0) begin
            st <= ST_DONE;
          end else begin
            st        <= ST_POST;
            post_left <= cfg_post;
          end
        end
      end else begin
        post_left <= post_left - 1'b1;
        if (post_left == AW'(1)) st <= ST_DONE;
      end
    end
  end

  assign we    = capturing;
  assign waddr = cur_addr;
  assign busy  = (st == ST_FILL) || (st == ST_POST);
  assign done  = (st == ST_DONE);

endmodule

// File: rtl/trace_reader.sv
module trace_reader #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          done,
  input  logic [AW-1:0] trig_addr,
  input  logic [AW-1:0] cfg_pre,
  input  logic [AW-1:0] cfg_post,
  input  logic          rd_ready,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic          rd_valid,
  output logic          rd_last
);

  logic [AW-1:0] rd_ptr;
  logic [AW:0]   rd_left;
  logic          done_q;
  logic          start;
  logic          load;

  always_comb begin
    start = done && !done_q && !abort;
    load  = done && !abort && !start && (rd_left != '0) && (!rd_valid || rd_ready);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_left  <= '0;
      done_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else if (abort) begin
      done_q   <= 1'b0;
      rd_left  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      done_q <= done;
      if (start) begin
        rd_ptr  <= trig_addr - cfg_pre;
        rd_left <= {1'b0, cfg_pre} + {1'b0, cfg_post} + 1'b1;
      end else if (load) begin
        rd_ptr   <= rd_ptr + 1'b1;
        rd_left  <= rd_left - 1'b1;
        rd_valid <= 1'b1;
        rd_last  <= (rd_left == (AW+1)'(1));
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
        rd_last  <= 1'b0;
      end
    end
  end

  assign re    = load;
  assign raddr = rd_ptr;

endmodule

// File: rtl/trace_window_recorder.sv
module trace_window_recorder #(
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int PIPE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] probe,
  input  logic          arm,
  input  logic          trig,
  input  logic [AW-1:0] pre_cnt,
  input  logic [AW-1:0] post_cnt,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] trig_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);

  localparam int PW = DW + 2;

  logic [PW-1:0] pipe_in;
  logic [PW-1:0] pipe_out;
  logic          s_arm;
  logic          s_trig;
  logic [DW-1:0] s_probe;
  logic [AW-1:0] cfg_pre;
  logic [AW-1:0] cfg_post;
  logic          we;
  logic [AW-1:0] waddr;
  logic          re;
  logic [AW-1:0] raddr;

  // counts are taken when arm is seen at the input
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pre  <= '0;
      cfg_post <= '0;
    end else if (arm) begin
      cfg_pre  <= pre_cnt;
      cfg_post <= post_cnt;
    end
  end

  assign pipe_in = {arm, trig, probe};

  trace_pipe #(.W(PW), .STAGES(PIPE)) u_pipe (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pipe_in),
    .q     (pipe_out)
  );

  assign s_arm   = pipe_out[DW+1];
  assign s_trig  = pipe_out[DW];
  assign s_probe = pipe_out[DW-1:0];

  trace_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_arm     (s_arm),
    .s_trig    (s_trig),
    .cfg_pre   (cfg_pre),
    .cfg_post  (cfg_post),
    .we        (we),
    .waddr     (waddr),
    .trig_addr (trig_addr),
    .busy      (busy),
    .done      (done)
  );

  trace_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (s_probe),
    .re    (re),
    .raddr (raddr),
    .rdata (rd_data)
  );

  trace_reader #(.AW(AW)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (s_arm),
    .done      (done),
    .trig_addr (trig_addr),
    .cfg_pre   (cfg_pre),
    .cfg_post  (cfg_post),
    .rd_ready  (rd_ready),
    .re        (re),
    .raddr     (raddr),
    .rd_valid  (rd_valid),
    .rd_last   (rd_last)
  );

endmodule

// File: rtl/trace_window_recorder_chk.sv
module trace_window_recorder_chk #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] trig_addr,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          rd_last
);

  // R5: capture phase and finished phase never overlap
  a_r5_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5: a capture only ever ends by reaching the finished state
  a_r5_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8: done is only left through a restart
  a_r8_done_left_by_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> busy);

  // R6: readout beats appear only while the window is held
  a_r6_valid_only_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  // R6: the last marker accompanies a valid beat
  a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  // R7: stalled beat is held until accepted
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && done) |=>
      (!done || (rd_valid && $stable(rd_data) && $stable(rd_last))));

  // R3: trigger address does not move while the window is held
  a_r3_trig_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(trig_addr));

endmodule

bind trace_window_recorder trace_window_recorder_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .trig_addr (trig_addr),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .rd_last   (rd_last)
);

// File: tb/trace_window_recorder_bench.sv
`timescale 1ns/1ps
module trace_window_recorder_bench;

  localparam int DW    = 8;
  localparam int AW    = 5;
  localparam int L     = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] probe;
  logic          arm;
  logic          trig;
  logic [AW-1:0] pre_cnt;
  logic [AW-1:0] post_cnt;
  logic          busy;
  logic          done;
  logic [AW-1:0] trig_addr;
  logic          rd_valid;
  logic          rd_ready;
  logic [DW-1:0] rd_data;
  logic          rd_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  trace_window_recorder #(.DW(DW), .AW(AW), .PIPE(L)) u_trace_window_recorder (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe     (probe),
    .arm       (arm),
    .trig      (trig),
    .pre_cnt   (pre_cnt),
    .post_cnt  (post_cnt),
    .busy      (busy),
    .done      (done),
    .trig_addr (trig_addr),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_last   (rd_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic readout(input int n, input logic [DW-1:0] first, input int pattern);
    int got = 0;
    int idle_after = 0;
    bit stalled = 1'b0;
    logic [DW-1:0] held_d = '0;
    logic held_l = 1'b0;
    for (int k = 0; k < 400 && idle_after < 4; k++) begin
      @(negedge clk);
      if (stalled)
        chk(rd_valid && rd_data == held_d && rd_last == held_l,
            "R7 beat held under stall", int'(rd_data), int'(held_d));
      rd_ready = (pattern == 0) ? 1'b1 : ((k % 3) != 1);
      #1;
      stalled = rd_valid && !rd_ready;
      held_d  = rd_data;
      held_l  = rd_last;
      if (rd_valid && rd_ready) begin
        if (got < n) begin
          chk(rd_data == first + DW'(got), "R6 readout order", int'(rd_data), int'(first + DW'(got)));
          chk(rd_last == (got == n - 1), "R6 last marker", int'(rd_last), int'(got == n - 1));
        end else begin
          chk(1'b0, "R6 extra beat", got, n);
        end
        got++;
      end
      if (got >= n && !rd_valid) idle_after++;
    end
    chk(got == n, "R6 beat count", got, n);
    chk(done == 1'b1, "R8 done held after readout", int'(done), 1);
    rd_ready = 1'b0;
  endtask

  task automatic capture(input int pre, input int post, input int ta, input int tb,
                         input logic [DW-1:0] base, input bit from_idle,
                         input int abort_at, input int pattern);
    int tr = -1;
    int exp_done;
    int i_done = -1;
    if (ta >= 0 && ta >= pre)      tr = ta;
    else if (tb >= 0 && tb >= pre) tr = tb;
    exp_done = tr + post + L + 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (abort_at > 0 && i == abort_at) begin
        arm = 1'b0; trig = 1'b0;
        return;
      end
      if (i == L)
        chk(busy == !from_idle, "R2 busy before arm arrives", int'(busy), int'(!from_idle));
      if (i == L + 1 && (abort_at > 0 || exp_done > L + 1))
        chk(busy == 1'b1, "R2 busy after pipeline delay", int'(busy), 1);
      if (i > L && done) begin
        i_done = i;
        break;
      end
      probe    = base + DW'(i);
      arm      = (i == 0);
      trig     = (i == ta) || (i == tb);
      pre_cnt  = (i == 0) ? AW'(pre)  : ~AW'(pre);
      post_cnt = (i == 0) ? AW'(post) : ~AW'(post);
    end
    arm = 1'b0; trig = 1'b0; probe = 8'hEE;
    chk(i_done == exp_done, "R5 R9 capture end cycle", i_done, exp_done);
    chk(busy == 1'b0, "R5 busy low at end", int'(busy), 0);
    chk(int'(trig_addr) == tr % DEPTH, "R3 R4 trigger address", int'(trig_addr), tr % DEPTH);
    readout(pre + post + 1, base + DW'(tr - pre), pattern);
  endtask

  initial begin
    rst_n = 1'b0; probe = '0; arm = 1'b0; trig = 1'b0;
    pre_cnt = '0; post_cnt = '0; rd_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid && !rd_last, "R1 idle in reset", int'({busy, done, rd_valid, rd_last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_valid && !rd_last, "R1 idle after reset", int'({busy, done, rd_valid, rd_last}), 0);

    // basic window, free-flowing readout
    capture(4, 5, 10, -1, 8'h10, 1'b1, 0, 0);
    // early trigger ignored (R4), later one taken, stalls on readout
    capture(8, 3, 3, 12, 8'h40, 1'b1, 0, 1);
    // trigger after the write pointer has wrapped (R3)
    capture(10, 12, 45, -1, 8'h80, 1'b1, 0, 1);
    // zero post count: ends on the trigger sample (R5)
    capture(5, 0, 7, -1, 8'h20, 1'b1, 0, 0);
    // window fills the whole memory
    capture(20, 11, 40, -1, 8'h00, 1'b1, 0, 1);
    // restart during capture (R8): history from the aborted run must not count
    capture(4, 0, -1, -1, 8'h50, 1'b1, 10, 0);
    capture(6, 3, 3, 9, 8'h60, 1'b0, 0, 1);
    // zero pre count: trigger on the arming sample
    capture(0, 4, 0, -1, 8'h30, 1'b1, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule